// File: doc/BRIEF.md
# Single-Level Page Translator

This block turns a 16-bit virtual address into a 15-bit physical address through a sixteen-entry page map held in flip-flops. The upper four bits of the address pick an entry. The entry's 3-bit frame number replaces them, and the 12-bit offset passes through unchanged, so virtual address 4097 (page 1, offset 1) lands at offset 1 of whatever frame page 1 maps to.

Each entry also carries per-page status. A present flag marks the page as mapped, and two permission bits allow reads and writes. A cache-disable flag is forwarded with every translation. A referenced flag and a modified flag are kept up to date by the translator on every access.

Supervisor software fills entries through a single-entry load port. It can wipe every referenced flag at once with a strobe, and it reads the status of any entry through a combinational status port. A request is answered one clock later with exactly one of three outcomes: a translated address, a not-present fault or a permission fault. Both faults report the offending page number.

Top module: `pgx_translator`

## Requirements
- R1: One cycle after a request whose entry is present and permits the access, `xl_valid` is high and `xl_addr` equals the entry's frame number in bits 14:12 with request address bits 11:0 in bits 11:0.
- R2: One cycle after a request to an entry whose present flag is 0, `pg_fault` is high, `fault_page` equals request address bits 15:12, and `xl_valid` and `perm_fault` are low.
- R3: Permission bit 0 allows reads and bit 1 allows writes. One cycle after a request to a present entry whose permission bit for that access type is 0, `perm_fault` is high with `fault_page` set to the page, and `xl_valid` and `pg_fault` are low.
- R4: A request to a present entry sets its referenced flag, whether or not the access is permitted. A request to an absent entry changes no flag. `st_ref`/`st_mod` show the flags of entry `st_idx` combinationally.
- R5: The modified flag of an entry is set only by a permitted write. Reads and denied writes leave it unchanged.
- R6: A load through the table port replaces frame, present, permission and cache-disable of entry `tw_idx` and clears its referenced and modified flags. This takes priority over a status update from a request to the same entry in the same cycle.
- R7: `ref_clr` clears the referenced flag of every entry in one cycle and leaves modified flags alone. A request in the same cycle still leaves its own entry's referenced flag set.
- R8: After reset all entries are absent with referenced and modified flags at 0, and all outputs are 0.
- R9: `xl_nocache` equals the cache-disable flag of the entry used, and is high only together with `xl_valid`.
- R10: Outputs pulse for exactly one cycle per request and are all 0 in a cycle after no request. `xl_addr` is 0 while `xl_valid` is low, and `fault_page` is 0 while neither fault is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | Request is a write (1) or read (0) |
| req_vaddr | input | 16 | Virtual address |
| tw_en | input | 1 | Load one page-map entry |
| tw_idx | input | 4 | Entry to load |
| tw_frame | input | 3 | Frame number to load |
| tw_present | input | 1 | Present flag to load |
| tw_perm | input | 2 | Permission bits to load (bit 0 read, bit 1 write) |
| tw_nocache | input | 1 | Cache-disable flag to load |
| ref_clr | input | 1 | Clear all referenced flags |
| st_idx | input | 4 | Entry whose status is shown |
| st_ref | output | 1 | Referenced flag of entry st_idx |
| st_mod | output | 1 | Modified flag of entry st_idx |
| xl_valid | output | 1 | Translated address valid |
| xl_addr | output | 15 | Physical address |
| xl_nocache | output | 1 | Cache-disable flag of translated page |
| pg_fault | output | 1 | Page not present |
| perm_fault | output | 1 | Access type not permitted |
| fault_page | output | 4 | Page number of the faulting request |

## Verification
The bench loads all sixteen entries from an arithmetic pattern that mixes absent pages, every permission combination and both cache settings. It then reads and writes every page, and predicts each outcome and flag. A translator that checked permissions on absent pages would raise the wrong fault. One that set modified on a denied write, or referenced on an absent page, would show a flag that the status port exposes. The bench also collides a load with a request to the same entry, and the clear strobe with a request. A design with the wrong priority leaves a stale referenced flag in the first case and loses the fresh one in the second.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  // Position of each permission bit inside an entry's permission field.
  localparam int unsigned PERM_RD = 0;
  localparam int unsigned PERM_WR = 1;
  localparam int unsigned PERM_W  = 2;

  // Outcome of one request.
  typedef enum logic [1:0] {
    OUTC_NONE   = 2'd0,
    OUTC_XLATE  = 2'd1,
    OUTC_PGFLT  = 2'd2,
    OUTC_PRMFLT = 2'd3
  } pgx_outcome_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table
  import pgx_pkg::*;
#(
  parameter int unsigned VPN_W = 4,
  parameter int unsigned PFN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_en,
  input  logic [VPN_W-1:0]  tw_idx,
  input  logic [PFN_W-1:0]  tw_frame,
  input  logic              tw_present,
  input  logic [PERM_W-1:0] tw_perm,
  input  logic              tw_nocache,
  input  logic              ref_clr,
  input  logic              upd_en,
  input  logic [VPN_W-1:0]  upd_idx,
  input  logic              upd_mod,
  input  logic [VPN_W-1:0]  rd_idx,
  output logic [PFN_W-1:0]  rd_frame,
  output logic              rd_present,
  output logic [PERM_W-1:0] rd_perm,
  output logic              rd_nocache,
  input  logic [VPN_W-1:0]  st_idx,
  output logic              st_ref,
  output logic              st_mod
);
  localparam int unsigned NPAGE = 1 << VPN_W;

  logic [PFN_W-1:0]  frame_v [NPAGE];
  logic [PERM_W-1:0] perm_v  [NPAGE];
  logic [NPAGE-1:0]  present_v, nocache_v, ref_v, mod_v;

  for (genvar g = 0; g < NPAGE; g++) begin : g_ent
    logic [PFN_W-1:0]  frame_q, frame_d;
    logic [PERM_W-1:0] perm_q, perm_d;
    logic              present_q, present_d, nc_q, nc_d;
    logic              ref_q, ref_d, mod_q, mod_d;
    logic              load_hit, upd_hit;

    assign load_hit = tw_en  && (tw_idx  == VPN_W'(g));
    assign upd_hit  = upd_en && (upd_idx == VPN_W'(g));

    always_comb begin
      frame_d   = frame_q;
      perm_d    = perm_q;
      present_d = present_q;
      nc_d      = nc_q;
      ref_d     = ref_q;
      mod_d     = mod_q;
      if (load_hit) begin
        frame_d   = tw_frame;
        perm_d    = tw_perm;
        present_d = tw_present;
        nc_d      = tw_nocache;
        ref_d     = 1'b0;
        mod_d     = 1'b0;
      end else begin
        if (ref_clr) ref_d = 1'b0;
        if (upd_hit) begin
          ref_d = 1'b1;
          if (upd_mod) mod_d = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_q   <= '0;
        perm_q    <= '0;
        present_q <= 1'b0;
        nc_q      <= 1'b0;
        ref_q     <= 1'b0;
        mod_q     <= 1'b0;
      end else begin
        if (load_hit) begin
          frame_q   <= frame_d;
          perm_q    <= perm_d;
          present_q <= present_d;
          nc_q      <= nc_d;
        end
        if (load_hit || upd_hit || ref_clr) begin
          ref_q <= ref_d;
          mod_q <= mod_d;
        end
      end
    end

    assign frame_v[g]   = frame_q;
    assign perm_v[g]    = perm_q;
    assign present_v[g] = present_q;
    assign nocache_v[g] = nc_q;
    assign ref_v[g]     = ref_q;
    assign mod_v[g]     = mod_q;
  end

  assign rd_frame   = frame_v[rd_idx];
  assign rd_perm    = perm_v[rd_idx];
  assign rd_present = present_v[rd_idx];
  assign rd_nocache = nocache_v[rd_idx];
  assign st_ref     = ref_v[st_idx];
  assign st_mod     = mod_v[st_idx];
endmodule

// File: rtl/pgx_check.sv
module pgx_check
  import pgx_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              present,
  input  logic [PERM_W-1:0] perm,
  output pgx_outcome_e      outcome,
  output logic              upd_en,
  output logic              upd_mod
);
  logic allowed;

  assign allowed = req_write ? perm[PERM_WR] : perm[PERM_RD];

  always_comb begin
    outcome = OUTC_NONE;
    upd_en  = 1'b0;
    upd_mod = 1'b0;
    if (req_valid) begin
      if (!present) begin
        outcome = OUTC_PGFLT;
      end else begin
        upd_en = 1'b1;
        if (allowed) begin
          outcome = OUTC_XLATE;
          upd_mod = req_write;
        end else begin
          outcome = OUTC_PRMFLT;
        end
      end
    end
  end
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
#(
  parameter int unsigned VPN_W = 4,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PFN_W = 3,
  localparam int unsigned VA_W = VPN_W + OFF_W,
  localparam int unsigned PA_W = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              tw_en,
  input  logic [VPN_W-1:0]  tw_idx,
  input  logic [PFN_W-1:0]  tw_frame,
  input  logic              tw_present,
  input  logic [PERM_W-1:0] tw_perm,
  input  logic              tw_nocache,
  input  logic              ref_clr,
  input  logic [VPN_W-1:0]  st_idx,
  output logic              st_ref,
  output logic              st_mod,
  output logic              xl_valid,
  output logic [PA_W-1:0]   xl_addr,
  output logic              xl_nocache,
  output logic              pg_fault,
  output logic              perm_fault,
  output logic [VPN_W-1:0]  fault_page
);
  logic [VPN_W-1:0]  vpn;
  logic [OFF_W-1:0]  offs;
  logic [PFN_W-1:0]  e_frame;
  logic              e_present, e_nocache;
  logic [PERM_W-1:0] e_perm;
  pgx_outcome_e      outcome;
  logic              upd_en, upd_mod;

  assign vpn  = req_vaddr[VA_W-1:OFF_W];
  assign offs = req_vaddr[OFF_W-1:0];

  pgx_table #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_frame(tw_frame),
    .tw_present(tw_present), .tw_perm(tw_perm), .tw_nocache(tw_nocache),
    .ref_clr(ref_clr),
    .upd_en(upd_en), .upd_idx(vpn), .upd_mod(upd_mod),
    .rd_idx(vpn), .rd_frame(e_frame), .rd_present(e_present),
    .rd_perm(e_perm), .rd_nocache(e_nocache),
    .st_idx(st_idx), .st_ref(st_ref), .st_mod(st_mod)
  );

  pgx_check u_check (
    .req_valid(req_valid), .req_write(req_write),
    .present(e_present), .perm(e_perm),
    .outcome(outcome), .upd_en(upd_en), .upd_mod(upd_mod)
  );

  // Response registers: next-state then register.
  logic              xv_d, xv_q, nc_d, nc_q, pf_d, pf_q, mf_d, mf_q;
  logic [PA_W-1:0]   pa_d, pa_q;
  logic [VPN_W-1:0]  fp_d, fp_q;

  always_comb begin
    xv_d = 1'b0;
    nc_d = 1'b0;
    pf_d = 1'b0;
    mf_d = 1'b0;
    pa_d = '0;
    fp_d = '0;
    unique case (outcome)
      OUTC_XLATE: begin
        xv_d = 1'b1;
        nc_d = e_nocache;
        pa_d = {e_frame, offs};
      end
      OUTC_PGFLT: begin
        pf_d = 1'b1;
        fp_d = vpn;
      end
      OUTC_PRMFLT: begin
        mf_d = 1'b1;
        fp_d = vpn;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xv_q <= 1'b0;
      nc_q <= 1'b0;
      pf_q <= 1'b0;
      mf_q <= 1'b0;
      pa_q <= '0;
      fp_q <= '0;
    end else begin
      xv_q <= xv_d;
      nc_q <= nc_d;
      pf_q <= pf_d;
      mf_q <= mf_d;
      pa_q <= pa_d;
      fp_q <= fp_d;
    end
  end

  assign xl_valid   = xv_q;
  assign xl_nocache = nc_q;
  assign pg_fault   = pf_q;
  assign perm_fault = mf_q;
  assign xl_addr    = pa_q;
  assign fault_page = fp_q;
endmodule

// File: rtl/pgx_translator_chk.sv
module pgx_translator_chk #(
  parameter int unsigned VPN_W = 4,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PFN_W = 3,
  localparam int unsigned VA_W = VPN_W + OFF_W,
  localparam int unsigned PA_W = PFN_W + OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             tw_en,
  input logic [VPN_W-1:0] tw_idx,
  input logic             ref_clr,
  input logic [VPN_W-1:0] st_idx,
  input logic             st_ref,
  input logic             st_mod,
  input logic             xl_valid,
  input logic [PA_W-1:0]  xl_addr,
  input logic             xl_nocache,
  input logic             pg_fault,
  input logic             perm_fault,
  input logic [VPN_W-1:0] fault_page
);
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> xl_addr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  // R2
  fault_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_fault || perm_fault) |-> fault_page == $past(req_vaddr[VA_W-1:OFF_W]));

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xl_valid, pg_fault, perm_fault}));

  // R6
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tw_en) && $past(tw_idx) == st_idx) |-> (!st_ref && !st_mod));

  // R7
  ref_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_clr) && !$past(req_valid)) |-> !st_ref);

  // R9
  nocache_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_nocache |-> xl_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !(xl_valid || pg_fault || perm_fault));
endmodule

bind pgx_translator pgx_translator_chk #(
  .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
) u_chk (.*);

// File: tb/pgx_translator_tb.sv
module pgx_translator_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_vaddr;
  logic        tw_en, tw_present, tw_nocache, ref_clr;
  logic [3:0]  tw_idx, st_idx, fault_page;
  logic [2:0]  tw_frame;
  logic [1:0]  tw_perm;
  logic        st_ref, st_mod, xl_valid, xl_nocache, pg_fault, perm_fault;
  logic [14:0] xl_addr;

  pgx_translator dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench-side page map model
  logic [2:0] m_frame [16];
  logic [1:0] m_perm  [16];
  logic       m_pres [16], m_nc [16], m_ref [16], m_mod [16];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_status(input int i, input string req);
    st_idx = 4'(i);
    #1;
    chk(st_ref == m_ref[i], req, {31'd0, st_ref}, {31'd0, m_ref[i]});
    chk(st_mod == m_mod[i], req, {31'd0, st_mod}, {31'd0, m_mod[i]});
  endtask

  task automatic load(input int i, input logic [2:0] f, input logic p, input logic [1:0] pm, input logic nc);
    tw_en = 1; tw_idx = 4'(i); tw_frame = f; tw_present = p; tw_perm = pm; tw_nocache = nc;
    @(negedge clk);
    tw_en = 0;
    m_frame[i] = f; m_pres[i] = p; m_perm[i] = pm; m_nc[i] = nc; m_ref[i] = 0; m_mod[i] = 0;
  endtask

  // Expected response after one request, updates model as required.
  task automatic expect_resp(input logic wr, input logic [15:0] va);
    int p;
    logic ok;
    p  = int'(va[15:12]);
    ok = m_pres[p] && (wr ? m_perm[p][1] : m_perm[p][0]);
    chk(xl_valid == ok, "R1 valid", {31'd0, xl_valid}, {31'd0, ok});
    chk(xl_addr == (ok ? {m_frame[p], va[11:0]} : 15'd0), "R1/R10 address",
        {17'd0, xl_addr}, ok ? {17'd0, m_frame[p], va[11:0]} : 32'd0);
    chk(pg_fault == !m_pres[p], "R2 page fault", {31'd0, pg_fault}, {31'd0, !m_pres[p]});
    chk(perm_fault == (m_pres[p] && !ok), "R3 permission fault",
        {31'd0, perm_fault}, {31'd0, m_pres[p] && !ok});
    chk(fault_page == (ok ? 4'd0 : va[15:12]), "R2/R3 fault page",
        {28'd0, fault_page}, ok ? 32'd0 : {28'd0, va[15:12]});
    chk(xl_nocache == (ok && m_nc[p]), "R9 nocache", {31'd0, xl_nocache}, {31'd0, ok && m_nc[p]});
    if (m_pres[p]) m_ref[p] = 1;        // R4
    if (ok && wr)  m_mod[p] = 1;        // R5
  endtask

  task automatic access(input logic wr, input logic [15:0] va);
    req_valid = 1; req_write = wr; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    expect_resp(wr, va);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_vaddr = '0;
    tw_en = 0; tw_idx = '0; tw_frame = '0; tw_present = 0; tw_perm = '0; tw_nocache = 0;
    ref_clr = 0; st_idx = '0;
    rst_n = 0;
    for (int i = 0; i < 16; i++) begin
      m_frame[i] = 0; m_perm[i] = 0; m_pres[i] = 0; m_nc[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8: reset state
    chk(!(xl_valid || pg_fault || perm_fault || xl_nocache) && xl_addr == 0 && fault_page == 0,
        "R8 outputs", {29'd0, xl_valid, pg_fault, perm_fault}, 32'd0);
    for (int i = 0; i < 16; i++) chk_status(i, "R8 flags");
    access(0, 16'h3abc);  // R8: absent after reset -> page fault

    // Load every entry from an arithmetic pattern
    for (int i = 0; i < 16; i++)
      load(i, 3'((i * 3 + 1) % 8), (i % 5) != 4, 2'(i % 4), 1'((i / 2) % 2));

    // Exhaustive sweep: every page, read and write, several offsets
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 3; k++) begin
        logic [11:0] off;
        off = 12'((k * 1365 + i * 7) % 4096);
        access(0, {4'(i), off});
        chk_status(i, "R4 after read");
        access(1, {4'(i), off ^ 12'hfff});
        chk_status(i, "R5 after write");
      end
    end

    // R1: address 4097 is page 1 offset 1
    access(0, 16'd4097);

    // R10: idle cycle yields nothing
    @(negedge clk);
    chk(!(xl_valid || pg_fault || perm_fault), "R10 idle", {29'd0, xl_valid, pg_fault, perm_fault}, 32'd0);

    // R7: clear strobe wipes referenced flags, keeps modified
    ref_clr = 1;
    @(negedge clk);
    ref_clr = 0;
    for (int i = 0; i < 16; i++) m_ref[i] = 0;
    for (int i = 0; i < 16; i++) chk_status(i, "R7 wipe");

    // R7: clear strobe concurrent with a request to page 3 (readable+writable)
    ref_clr = 1;
    req_valid = 1; req_write = 0; req_vaddr = 16'h3010;
    @(negedge clk);
    ref_clr = 0; req_valid = 0;
    expect_resp(0, 16'h3010);
    chk_status(3, "R7 concurrent request keeps own flag");
    access(0, 16'h7020);
    ref_clr = 1;
    @(negedge clk);
    ref_clr = 0;
    for (int i = 0; i < 16; i++) m_ref[i] = 0;
    chk_status(7, "R7 second wipe");

    // R6: load concurrent with a write request to the same entry
    access(1, 16'h7abc);
    tw_en = 1; tw_idx = 4'd7; tw_frame = 3'd5; tw_present = 1; tw_perm = 2'b11; tw_nocache = 1;
    req_valid = 1; req_write = 1; req_vaddr = 16'h7def;
    @(negedge clk);
    tw_en = 0; req_valid = 0;
    expect_resp(1, 16'h7def);      // answered from the old entry
    m_frame[7] = 3'd5; m_pres[7] = 1; m_perm[7] = 2'b11; m_nc[7] = 1; m_ref[7] = 0; m_mod[7] = 0;
    chk_status(7, "R6 load wins");
    access(0, 16'h7123);           // new frame and nocache in effect
    chk_status(7, "R6 reload then read");

    // R6/R2: unmapping a page by load
    load(2, 3'd0, 0, 2'b11, 0);
    access(1, 16'h2fff);
    chk_status(2, "R4 absent unchanged");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule